// File: doc/BRIEF.md
# Outcome-History Last-Value Load Predictor

This block guesses the data a load instruction will return, so that dependent work can start before memory answers. It keeps a direct-mapped table of lines, one per group of instruction addresses. Each line holds the last 64-bit value that load returned and a short shift register recording whether recent guesses for that line would have been right. The line's shift register does not decide confidence by itself. It is used as an index into a second, shared table of saturating up/down counters, and a guess is offered only when the selected counter lies above a programmable threshold.

A lookup presents an instruction address and receives, one cycle later, the stored value and a one-bit predict flag. An update presents the address and the true loaded value once the load has completed. The update adjusts the counter, then the history, then the stored value. A mode pin selects whether a wrong outcome decrements the counter or clears it to zero.

After reset, a synchronous sweep clears every line and counter, one entry per cycle. The busy flag is high during the sweep. Updates are refused during the sweep, and lookups still complete but never predict.

Handshakes: `lk_ready` is held high, so a lookup is taken on every cycle in which `lk_valid` is high. An update is taken only on a cycle where both `up_valid` and `up_ready` are high, and `up_ready` is low exactly while `busy` is high, so the sender must hold the update until then. The result port has no ready signal, and the consumer must take `rs_value` and `rs_predict` in the cycle `rs_valid` is high.

Top module: `ldval_predictor`

## Requirements
- R1: The line is selected by address bits [IDX_W+1:2]. Address bits [1:0] and all bits above IDX_W+1 are ignored, so two addresses that agree on bits [IDX_W+1:2] share one line. Lines carry no tag.
- R2: Each accepted lookup produces `rs_valid` high exactly one cycle later, with `rs_value` equal to the value currently stored in the selected line.
- R3: `rs_predict` is 1 only when the counter selected by the line's history is strictly greater than `thresh`. Equality gives 0.
- R4: On an update, the counter addressed by the line's current history is incremented when the true value equals the stored value, and it stays at its maximum 2^CTR_W-1. On a mismatch it is decremented, and it stays at 0.
- R5: After the counter step, the line's HIST_W-bit history shifts left by one and takes the new outcome into bit 0 (1 = match, 0 = mismatch). The oldest bit is dropped.
- R6: Every update overwrites the stored value with the true value, whatever the confidence. The outcome is computed whether or not a prediction was issued.
- R7: When `miss_clear` is 1, a mismatch sets the addressed counter to 0. A match still increments it.
- R8: After reset, `busy` stays high for max(2^IDX_W, 2^HIST_W) cycles while all values, histories and counters are cleared to zero. `up_ready` is low during this time, and lookups during it return `rs_predict` = 0.
- R9: A lookup and an update to the same line in the same cycle return the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the clearing sweep |
| thresh | input | CTR_W | Confidence threshold; predict when counter > thresh |
| miss_clear | input | 1 | 1: a mismatch clears the counter; 0: a mismatch decrements it |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup accepted (always high) |
| lk_addr | input | ADDR_W | Instruction address of the lookup |
| up_valid | input | 1 | Update request present |
| up_ready | output | 1 | Update accepted; low while busy |
| up_addr | input | ADDR_W | Instruction address of the completed load |
| up_value | input | VAL_W | True loaded value |
| busy | output | 1 | Clearing sweep in progress |
| rs_valid | output | 1 | Lookup result present, one cycle after acceptance |
| rs_value | output | VAL_W | Predicted value (last stored value of the line) |
| rs_predict | output | 1 | 1 = use the prediction; 0 = do not predict |

## Verification
Lookup results appear one clock after the accepting edge. An update changes state at its own edge, so a lookup accepted on the next cycle sees the new value, history and counter. The bench drives every request at a falling edge and records the expected result in a queue at that moment. Expectations come from a behavioural table model, evaluated before any same-cycle update is applied. A monitor checks each result at the next falling edge, and it flags any result that arrives with no entry waiting. The sweep length is counted in falling edges from the release of reset.

// File: rtl/ldval_pkg.sv
package ldval_pkg;

  // What a mismatched outcome does to the selected confidence counter.
  typedef enum logic {
    MISS_STEP_DOWN = 1'b0,
    MISS_TO_ZERO   = 1'b1
  } miss_policy_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ldval_sweep.sv
module ldval_sweep #(
  parameter int unsigned N  = 2048,
  parameter int unsigned PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          busy,
  output logic [PW-1:0] ptr
);

  localparam logic [PW-1:0] LAST = PW'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      if (ptr == LAST) begin
        busy <= 1'b0;
        ptr  <= '0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // R8: once the sweep has ended it stays ended until the next reset.
  p_sweep_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);

endmodule

// File: rtl/ldval_line_store.sv
module ldval_line_store #(
  parameter int unsigned IDX_W  = 11,
  parameter int unsigned HIST_W = 10,
  parameter int unsigned VAL_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VAL_W-1:0]  rd_val,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              up_en,
  input  logic [IDX_W-1:0]  up_idx,
  input  logic [VAL_W-1:0]  up_data,
  output logic [HIST_W-1:0] up_hist,
  output logic              up_hit
);

  localparam int unsigned LINES = 1 << IDX_W;

  logic [VAL_W-1:0]  val_q  [LINES];
  logic [HIST_W-1:0] hist_q [LINES];

  assign rd_val  = val_q[rd_idx];
  assign rd_hist = hist_q[rd_idx];
  assign up_hist = hist_q[up_idx];
  assign up_hit  = (val_q[up_idx] == up_data);

  always_ff @(posedge clk) begin
    if (clr_en) begin
      val_q[clr_idx]  <= '0;
      hist_q[clr_idx] <= '0;
    end else if (up_en) begin
      val_q[up_idx]  <= up_data;
      hist_q[up_idx] <= {up_hist[HIST_W-2:0], up_hit};
    end
  end

  // R6: the written line holds the true value after the update.
  p_val_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && !clr_en |=> val_q[$past(up_idx)] == $past(up_data));

  // R5: the newest outcome lands in bit 0 and older outcomes move up.
  p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && !clr_en |=> hist_q[$past(up_idx)] == {$past(up_hist[HIST_W-2:0]), $past(up_hit)});

endmodule

// File: rtl/ldval_conf_table.sv
module ldval_conf_table #(
  parameter int unsigned HIST_W = 10,
  parameter int unsigned CTR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_en,
  input  logic [HIST_W-1:0]        clr_idx,
  input  logic [HIST_W-1:0]        rd_hist,
  output logic [CTR_W-1:0]         rd_ctr,
  input  logic                     up_en,
  input  logic [HIST_W-1:0]        up_hist,
  input  logic                     up_hit,
  input  ldval_pkg::miss_policy_e  policy
);

  localparam int unsigned     CTRS = 1 << HIST_W;
  localparam logic [CTR_W-1:0] CMAX = '1;

  logic [CTR_W-1:0] ctr_q [CTRS];
  logic [CTR_W-1:0] cur;
  logic [CTR_W-1:0] nxt;

  assign rd_ctr = ctr_q[rd_hist];
  assign cur    = ctr_q[up_hist];

  always_comb begin
    if (up_hit)
      nxt = (cur == CMAX) ? cur : cur + 1'b1;
    else if (policy == ldval_pkg::MISS_TO_ZERO)
      nxt = '0;
    else
      nxt = (cur == '0) ? cur : cur - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr_en)
      ctr_q[clr_idx] <= '0;
    else if (up_en)
      ctr_q[up_hist] <= nxt;
  end

  // R4: a match at the top stays at the top.
  p_ctr_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && !clr_en && up_hit && cur == CMAX |=> ctr_q[$past(up_hist)] == CMAX);

  // R4: a mismatch at zero stays at zero.
  p_ctr_sat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && !clr_en && !up_hit && cur == '0 |=> ctr_q[$past(up_hist)] == '0);

  // R7: in the clearing mode a mismatch leaves the counter at zero.
  p_miss_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && !clr_en && !up_hit && policy == ldval_pkg::MISS_TO_ZERO
    |=> ctr_q[$past(up_hist)] == '0);

endmodule

// File: rtl/ldval_predictor.sv
module ldval_predictor #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned VAL_W  = 64,
  parameter int unsigned IDX_W  = 11,
  parameter int unsigned HIST_W = 10,
  parameter int unsigned CTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTR_W-1:0]  thresh,
  input  logic              miss_clear,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [VAL_W-1:0]  up_value,
  output logic              busy,
  output logic              rs_valid,
  output logic [VAL_W-1:0]  rs_value,
  output logic              rs_predict
);

  localparam int unsigned LINES   = 1 << IDX_W;
  localparam int unsigned CTRS    = 1 << HIST_W;
  localparam int unsigned SWEEP_N = ldval_pkg::max_u(LINES, CTRS);
  localparam int unsigned PTR_W   = ldval_pkg::max_u(IDX_W, HIST_W);

  logic [PTR_W-1:0]  sw_ptr;
  logic              line_clr, ctr_clr;
  logic              lk_fire, up_fire;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [VAL_W-1:0]  lk_val;
  logic [HIST_W-1:0] lk_hist, up_hist;
  logic              up_hit;
  logic [CTR_W-1:0]  lk_ctr;
  ldval_pkg::miss_policy_e policy;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{lk_addr[ADDR_W-1:IDX_W+2], lk_addr[1:0],
                              up_addr[ADDR_W-1:IDX_W+2], up_addr[1:0]};

  assign lk_ready = 1'b1;
  assign up_ready = !busy;
  assign lk_fire  = lk_valid && lk_ready;
  assign up_fire  = up_valid && up_ready;
  assign lk_idx   = lk_addr[IDX_W+1:2];
  assign up_idx   = up_addr[IDX_W+1:2];
  assign policy   = miss_clear ? ldval_pkg::MISS_TO_ZERO : ldval_pkg::MISS_STEP_DOWN;

  ldval_sweep #(.N(SWEEP_N), .PW(PTR_W)) u_sweep (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .ptr   (sw_ptr)
  );

  // The sweep runs over the larger of the two tables; the smaller one
  // only takes the pointer values that fit it.
  generate
    if (PTR_W > IDX_W) begin : g_line_clr_part
      assign line_clr = busy && (sw_ptr[PTR_W-1:IDX_W] == '0);
    end else begin : g_line_clr_full
      assign line_clr = busy;
    end
    if (PTR_W > HIST_W) begin : g_ctr_clr_part
      assign ctr_clr = busy && (sw_ptr[PTR_W-1:HIST_W] == '0);
    end else begin : g_ctr_clr_full
      assign ctr_clr = busy;
    end
  endgenerate

  ldval_line_store #(.IDX_W(IDX_W), .HIST_W(HIST_W), .VAL_W(VAL_W)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (line_clr),
    .clr_idx (sw_ptr[IDX_W-1:0]),
    .rd_idx  (lk_idx),
    .rd_val  (lk_val),
    .rd_hist (lk_hist),
    .up_en   (up_fire),
    .up_idx  (up_idx),
    .up_data (up_value),
    .up_hist (up_hist),
    .up_hit  (up_hit)
  );

  ldval_conf_table #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_conf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (ctr_clr),
    .clr_idx (sw_ptr[HIST_W-1:0]),
    .rd_hist (lk_hist),
    .rd_ctr  (lk_ctr),
    .up_en   (up_fire),
    .up_hist (up_hist),
    .up_hit  (up_hit),
    .policy  (policy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid   <= 1'b0;
      rs_value   <= '0;
      rs_predict <= 1'b0;
    end else begin
      rs_valid <= lk_fire;
      if (lk_fire) begin
        rs_value   <= lk_val;
        rs_predict <= !busy && (lk_ctr > thresh);
      end
    end
  end

  // R2: an accepted lookup is answered on the following cycle.
  p_result_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> rs_valid);

  // R8: no lookup taken during the sweep may predict.
  p_busy_nopred_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && $past(busy) |-> !rs_predict);

endmodule

// File: tb/ldval_predictor_bench.sv
module ldval_predictor_bench;

  localparam int unsigned IW = 4;
  localparam int unsigned HW = 3;
  localparam int unsigned CW = 3;
  localparam int unsigned NL = 1 << IW;
  localparam int unsigned NC = 1 << HW;
  localparam int unsigned SWEEP = (NL > NC) ? NL : NC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] thresh = '0;
  logic          miss_clear = 1'b0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [63:0]   lk_addr = '0;
  logic          up_valid = 1'b0;
  logic          up_ready;
  logic [63:0]   up_addr = '0;
  logic [63:0]   up_value = '0;
  logic          busy;
  logic          rs_valid;
  logic [63:0]   rs_value;
  logic          rs_predict;

  always #10 clk = ~clk;

  ldval_predictor #(.ADDR_W(64), .VAL_W(64), .IDX_W(IW), .HIST_W(HW), .CTR_W(CW))
  u_ldval_predictor (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .miss_clear(miss_clear),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_value(up_value),
    .busy(busy), .rs_valid(rs_valid), .rs_value(rs_value), .rs_predict(rs_predict)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural table model
  logic [63:0]   mval  [NL];
  logic [HW-1:0] mhist [NL];
  logic [CW-1:0] mctr  [NC];
  bit            mbusy;

  // scoreboard
  logic [63:0] q_v [$];
  bit          q_p [$];
  bit          q_c [$];
  string       q_t [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NL; i++) begin mval[i] = '0; mhist[i] = '0; end
    for (int i = 0; i < NC; i++) mctr[i] = '0;
  endtask

  function automatic logic [63:0] mk_addr(input int idx, input int tagk);
    return (64'(tagk) << (IW + 2)) | (64'(idx) << 2) | 64'(tagk & 3);
  endfunction

  // One cycle: optional lookup and optional update, driven at a falling edge.
  task automatic step(input bit dl, input logic [63:0] la, input bit du,
                      input logic [63:0] ua, input logic [63:0] uv,
                      input bit chkv, input string tag);
    int li, ui;
    logic [CW-1:0] c;
    logic [HW-1:0] h;
    bit hit;
    li = int'(la[IW+1:2]);
    ui = int'(ua[IW+1:2]);
    lk_valid = dl; lk_addr = la;
    up_valid = du; up_addr = ua; up_value = uv;
    if (dl) begin
      q_v.push_back(mval[li]);
      q_p.push_back(!mbusy && (mctr[mhist[li]] > thresh));
      q_c.push_back(chkv);
      q_t.push_back(tag);
    end
    if (du && !mbusy) begin
      hit = (mval[ui] == uv);
      h = mhist[ui];
      c = mctr[h];
      if (hit) c = (c == '1) ? c : c + 1'b1;
      else if (miss_clear) c = '0;
      else c = (c == '0) ? c : c - 1'b1;
      mctr[h] = c;
      mhist[ui] = {h[HW-2:0], hit};
      mval[ui] = uv;
    end
    @(negedge clk);
    lk_valid = 1'b0;
    up_valid = 1'b0;
  endtask

  task automatic look(input int idx, input int tagk, input string tag);
    step(1'b1, mk_addr(idx, tagk), 1'b0, '0, '0, 1'b1, tag);
  endtask

  task automatic upd(input int idx, input int tagk, input logic [63:0] v);
    step(1'b0, '0, 1'b1, mk_addr(idx, tagk), v, 1'b0, "");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rs_valid) begin
      if (q_v.size() == 0) begin
        check(1'b0, "R2 unexpected result", {63'd0, rs_valid}, 64'd0);
      end else begin
        logic [63:0] ev; bit ep; bit ec; string et;
        ev = q_v.pop_front(); ep = q_p.pop_front();
        ec = q_c.pop_front(); et = q_t.pop_front();
        if (ec) check(rs_value == ev, {et, " value"}, rs_value, ev);
        check(rs_predict == ep, {et, " predict"}, {63'd0, rs_predict}, {63'd0, ep});
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    mbusy = 1'b1;
    repeat (3) @(negedge clk);
    q_v.delete(); q_p.delete(); q_c.delete(); q_t.delete();
    rst_n = 1'b1;
  endtask

  task automatic run_sweep(input string tag);
    int cnt;
    check(busy == 1'b1, {tag, " R8 busy at release"}, {63'd0, busy}, 64'd1);
    check(up_ready == 1'b0, {tag, " R8 up_ready during sweep"}, {63'd0, up_ready}, 64'd0);
    check(lk_ready == 1'b1, {tag, " R2 lk_ready"}, {63'd0, lk_ready}, 64'd1);
    cnt = 0;
    // lookup during the sweep must not predict
    step(1'b1, mk_addr(3, 0), 1'b0, '0, '0, 1'b0, {tag, " R8 lookup while busy"});
    cnt++;
    while (busy && cnt < 4 * SWEEP) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == SWEEP, {tag, " R8 sweep length"}, 64'(cnt), 64'(SWEEP));
    mbusy = 1'b0;
    model_clear();
    check(up_ready == 1'b1, {tag, " R8 up_ready after sweep"}, {63'd0, up_ready}, 64'd1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    mbusy = 1'b1;
    @(negedge clk);
    do_reset();
    run_sweep("first");

    thresh = 3'd2;
    miss_clear = 1'b0;
    // R8: all state reads zero after the sweep
    look(3, 0, "R8 zero value");
    look(9, 2, "R8 zero value");

    // R4/R5/R6: a mismatch, then a run of matches on line 3
    upd(3, 0, 64'hA5A5_0000_1234_5678);
    look(3, 0, "R6 overwrite");
    for (int k = 0; k < 12; k++) begin
      upd(3, 0, 64'hA5A5_0000_1234_5678);
      look(3, 0, "R4 R5 training");
    end
    // R1: aliasing addresses and ignored low bits share line 3
    look(3, 5, "R1 alias");
    look(3, 3, "R1 alias");
    look(4, 0, "R1 neighbour line");

    // R3: strict comparison at the saturated counter (max 7)
    thresh = 3'd7;
    look(3, 0, "R3 equal threshold");
    thresh = 3'd6;
    look(3, 0, "R3 above threshold");

    // R4: mismatch decrements; R6 value replaced
    upd(3, 1, 64'h0000_0000_DEAD_BEEF);
    look(3, 0, "R4 decrement");
    for (int k = 0; k < 3; k++) begin
      upd(3, 0, 64'h0000_0000_DEAD_BEEF);
      look(3, 0, "R5 refill history");
    end

    // R7: clear-on-miss zeroes the counter for history 111
    miss_clear = 1'b1;
    thresh = 3'd0;
    for (int k = 0; k < 4; k++) upd(5, 0, 64'h77);
    look(5, 0, "R7 before miss");
    upd(5, 0, 64'h78);
    look(3, 0, "R7 counter cleared");
    upd(5, 0, 64'h78);
    look(5, 0, "R7 match increments");
    miss_clear = 1'b0;

    // R9: same-cycle lookup and update on one line
    step(1'b1, mk_addr(3, 0), 1'b1, mk_addr(3, 2), 64'h1111_2222_3333_4444, 1'b1, "R9 pre-update");
    look(3, 0, "R9 post-update");

    // R2: back-to-back lookups over several lines
    for (int i = 0; i < NL; i++) look(i, i, "R2 streaming");

    // R8: a second reset clears written state
    do_reset();
    run_sweep("second");
    look(3, 0, "R8 cleared after reset");
    look(5, 0, "R8 cleared after reset");

    repeat (3) @(negedge clk);
    check(q_v.size() == 0, "R2 missing results", 64'(q_v.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule